// File: doc/BRIEF.md
# SDRAM Command Decoder with Per-Bank State Tracking

This block sits on the device side of a single-data-rate SDRAM command bus. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe and write-enable pins into a command. It checks that command against the state of the bank it addresses, or of all banks for the global commands, and then updates a small state machine for each of four banks. The states are idle, row open, bursting a read and bursting a write. For each bank it records the row that was last opened. It pulses a flag whenever a command is not allowed in the current state, and a strobe whenever the mode word is loaded.

Address bit 10 qualifies two commands. On a read or write it asks for auto-precharge for that one access. On a precharge it widens the command to every bank. Burst length comes from the low three bits of the loaded mode word and sets how long each bank reports a burst. The byte-mask pins are handled with two different latencies. A write mask takes effect in the same cycle. A read-output disable appears after two register stages.

The block is meant to sit beside a memory model or a protocol monitor. It reports which bank states and command orders are legal; it does not hold data.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: After reset every bank is idle (state code 0), `illegal_cmd`, `mode_load`, `wr_mask` and `rd_mask` are 0, and `mode_opcode` is 0, which gives a burst length of 1.
- R2: An ACTIVE command to an idle bank makes that bank row-open (code 1) after the edge, and stores `addr` as its row in `open_row[11*b+10:11*b]`.
- R3: The pins {cs_n,ras_n,cas_n,we_n} decode as follows: 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 BURST STOP, 0010 PRECHARGE, 0001 REFRESH, 0000 MODE LOAD, and any value with cs_n=1 is an inhibit that is always legal. A READ or WRITE to an idle bank, or an ACTIVE to a bank that is not idle, is illegal. An illegal command sets `illegal_cmd` for the one cycle after its edge and issues nothing: a bank that is not bursting keeps its state and its row.
- R4: REFRESH is legal only when all banks are idle, and it changes no bank state.
- R5: PRECHARGE is always legal. With addr[10]=0 it returns only the bank selected by `ba` to idle. With addr[10]=1 it returns every bank to idle and `ba` is ignored.
- R6: MODE LOAD is legal only when all banks are idle. It then stores addr[10:0] in `mode_opcode` and raises `mode_load` for exactly one cycle.
- R7: Burst code mode_opcode[2:0]: 0 gives length 1, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives an open-ended burst, and other codes give 1. After a READ (WRITE) at an edge, the bank shows code 2 (3) for exactly the burst length in cycles and then returns to row-open. An open-ended burst lasts until it is stopped.
- R8: A READ or WRITE with addr[10]=1 returns its bank to idle instead of row-open when the burst ends. The request applies to that access only.
- R9: BURST STOP returns the bursting bank to row-open. It is illegal when no bank is bursting.
- R10: Only one burst runs at a time. A READ or WRITE to one bank ends a burst in any other bank (that bank goes idle if its burst asked for auto-precharge, otherwise row-open). A PRECHARGE to a bursting bank cuts its burst short and makes it idle.
- R11: `rd_mask` shows the `dqm` value sampled two edges earlier through two register stages: the value sampled at edge k appears in the cycle after edge k+1.
- R12: `wr_mask` equals `dqm` with no delay during the cycle of a legal WRITE and during every later data cycle of that write burst, and is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe pin |
| cas_n | input | 1 | Column strobe pin |
| we_n | input | 1 | Write-enable pin |
| ba | input | 2 | Bank select |
| addr | input | 11 | Row, column or mode word; bit 10 is the qualifier |
| dqm | input | 4 | Byte mask pins |
| bank_state | output | 8 | Two-bit state per bank, bank b at [2b+1:2b] |
| open_row | output | 44 | Stored row per bank, bank b at [11b+10:11b] |
| illegal_cmd | output | 1 | One-cycle pulse after a disallowed command |
| mode_load | output | 1 | One-cycle pulse after a mode load |
| mode_opcode | output | 11 | Current mode word |
| wr_mask | output | 4 | Write byte mask, same cycle |
| rd_mask | output | 4 | Read output disable, two-stage delayed |

## Verification
On every cycle the assertions check the following. An ACTIVE only ever reaches an idle bank. Reads and writes only reach banks with an open row. Fixed bursts leave their state when the count runs out. No more than one bank bursts at a time. A mode load only follows a cycle with all banks idle. An illegal command leaves non-bursting banks untouched. The bench scenarios are needed to show exact burst lengths for each mode code, the auto-precharge ending and its one-access scope, and precharge-all ignoring the bank select. They also cover a burst in one bank being cut by a command to another, and the two mask latencies measured against the cycle of the pins.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_READ   = 2'd2,
      ST_WRITE  = 2'd3
   } bank_st_e;

   typedef enum logic [3:0] {
      C_INHIBIT,
      C_NOP,
      C_ACT,
      C_RD,
      C_WR,
      C_BST,
      C_PRE,
      C_REF,
      C_LMR
   } cmd_e;

   localparam int unsigned BL_CNT_W = 3;

   // remaining-beat count loaded when a burst starts (length minus one)
   function automatic logic [BL_CNT_W-1:0] burst_len_m1(input logic [2:0] code);
      logic [BL_CNT_W-1:0] r;
      case (code)
         3'd1:    r = 3'd1;
         3'd2:    r = 3'd3;
         3'd3:    r = 3'd7;
         default: r = 3'd0;
      endcase
      return r;
   endfunction

   function automatic logic burst_is_open(input logic [2:0] code);
      return code == 3'b111;
   endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
module sdr_cmd_decode
   import sdr_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = C_INHIBIT;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = C_NOP;
            3'b011:  cmd = C_ACT;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b110:  cmd = C_BST;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            default: cmd = C_LMR;
         endcase
      end
   end

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
   import sdr_trk_pkg::*;
#(
   parameter int unsigned ROW_W = 11,
   parameter int unsigned CNT_W = BL_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_act,
   input  logic             go_rd,
   input  logic             go_wr,
   input  logic             go_pre,
   input  logic             go_term,
   input  logic             go_cut,
   input  logic             ap_req,
   input  logic [ROW_W-1:0] row_in,
   input  logic [CNT_W-1:0] len_m1,
   input  logic             len_open,
   output bank_st_e         state_o,
   output logic [ROW_W-1:0] row_o,
   output logic             beats_left_o
);

   bank_st_e         state_q;
   logic [ROW_W-1:0] row_q;
   logic [CNT_W-1:0] cnt_q;
   logic             ap_q;
   logic             open_q;
   logic             bursting;
   logic             any_go;

   assign bursting = (state_q == ST_READ) || (state_q == ST_WRITE);
   assign any_go   = go_act | go_rd | go_wr | go_pre | go_term | go_cut;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         cnt_q   <= '0;
         ap_q    <= 1'b0;
         open_q  <= 1'b0;
      end else if (go_act) begin
         state_q <= ST_ACTIVE;
         row_q   <= row_in;
      end else if (go_pre) begin
         state_q <= ST_IDLE;
         ap_q    <= 1'b0;
      end else if (go_rd || go_wr) begin
         state_q <= go_wr ? ST_WRITE : ST_READ;
         ap_q    <= ap_req;
         cnt_q   <= len_m1;
         open_q  <= len_open;
      end else if (bursting && go_term) begin
         state_q <= ST_ACTIVE;
         ap_q    <= 1'b0;
      end else if (bursting && go_cut) begin
         state_q <= ap_q ? ST_IDLE : ST_ACTIVE;
         ap_q    <= 1'b0;
      end else if (bursting && !open_q) begin
         if (cnt_q == '0) begin
            state_q <= ap_q ? ST_IDLE : ST_ACTIVE;
            ap_q    <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign state_o      = state_q;
   assign row_o        = row_q;
   assign beats_left_o = bursting && (open_q || (cnt_q != '0));

   AST_ACT_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      go_act |-> state_q == ST_IDLE); // R2

   AST_RW_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (go_rd || go_wr) |-> state_q != ST_IDLE); // R3

   AST_FIXED_BURST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bursting && !open_q && cnt_q == '0 && !any_go) |=>
         (state_q == ST_ACTIVE || state_q == ST_IDLE)); // R7

endmodule

// File: rtl/sdr_dqm_timing.sv
module sdr_dqm_timing #(
   parameter int unsigned DQM_W  = 4,
   parameter int unsigned RD_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DQM_W-1:0] dqm,
   input  logic             wr_win,
   output logic [DQM_W-1:0] wr_mask,
   output logic [DQM_W-1:0] rd_mask
);

   assign wr_mask = wr_win ? dqm : '0;

   generate
      if (RD_LAT == 0) begin : g_rd_direct
         assign rd_mask = dqm;
      end else begin : g_rd_pipe
         logic [DQM_W-1:0] stage_q [RD_LAT];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < RD_LAT; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= dqm;
               for (int i = 1; i < RD_LAT; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign rd_mask = stage_q[RD_LAT-1];
      end
   endgenerate

endmodule

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker
   import sdr_trk_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned AP_BIT      = 10,
   parameter int unsigned DQM_W       = 4,
   parameter int unsigned RD_MASK_LAT = 2,
   localparam int unsigned BA_W       = $clog2(NUM_BANKS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cs_n,
   input  logic                        ras_n,
   input  logic                        cas_n,
   input  logic                        we_n,
   input  logic [BA_W-1:0]             ba,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [DQM_W-1:0]            dqm,
   output logic [NUM_BANKS*2-1:0]      bank_state,
   output logic [NUM_BANKS*ADDR_W-1:0] open_row,
   output logic                        illegal_cmd,
   output logic                        mode_load,
   output logic [ADDR_W-1:0]           mode_opcode,
   output logic [DQM_W-1:0]            wr_mask,
   output logic [DQM_W-1:0]            rd_mask
);

   generate
      if (NUM_BANKS != (1 << BA_W) || NUM_BANKS < 2) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (AP_BIT >= ADDR_W || ADDR_W < 3) begin : g_bad_addr
         $error("AP_BIT must lie inside the address and ADDR_W >= 3");
      end
   endgenerate

   cmd_e                cmd;
   bank_st_e            st     [NUM_BANKS];
   logic [ADDR_W-1:0]   row_v  [NUM_BANKS];
   logic [NUM_BANKS-1:0] idle_v, burst_v, wbeat_v;
   logic                all_idle, any_burst, legal, wr_win;
   bank_st_e            tgt_st;
   logic [ADDR_W-1:0]   mode_q;
   logic                mode_load_q, illegal_q;
   logic [BL_CNT_W-1:0] len_m1;
   logic                len_open;

   sdr_cmd_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign all_idle  = &idle_v;
   assign any_burst = |burst_v;
   assign tgt_st    = st[ba];
   assign len_m1    = burst_len_m1(mode_q[2:0]);
   assign len_open  = burst_is_open(mode_q[2:0]);

   always_comb begin
      case (cmd)
         C_ACT:        legal = (tgt_st == ST_IDLE);
         C_RD, C_WR:   legal = (tgt_st != ST_IDLE);
         C_BST:        legal = any_burst;
         C_REF, C_LMR: legal = all_idle;
         default:      legal = 1'b1;
      endcase
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic sel;
         logic go_act, go_rd, go_wr, go_pre, go_term, go_cut, beats;
         assign sel     = (ba == BA_W'(b));
         assign go_act  = legal && (cmd == C_ACT) && sel;
         assign go_rd   = legal && (cmd == C_RD) && sel;
         assign go_wr   = legal && (cmd == C_WR) && sel;
         assign go_pre  = legal && (cmd == C_PRE) && (sel || addr[AP_BIT]);
         assign go_term = legal && (cmd == C_BST);
         assign go_cut  = legal && ((cmd == C_RD) || (cmd == C_WR)) && !sel;

         sdr_bank_fsm #(.ROW_W(ADDR_W), .CNT_W(BL_CNT_W)) u_bank (
            .clk          (clk),
            .rst_n        (rst_n),
            .go_act       (go_act),
            .go_rd        (go_rd),
            .go_wr        (go_wr),
            .go_pre       (go_pre),
            .go_term      (go_term),
            .go_cut       (go_cut),
            .ap_req       (addr[AP_BIT]),
            .row_in       (addr),
            .len_m1       (len_m1),
            .len_open     (len_open),
            .state_o      (st[b]),
            .row_o        (row_v[b]),
            .beats_left_o (beats)
         );

         assign idle_v[b]  = (st[b] == ST_IDLE);
         assign burst_v[b] = (st[b] == ST_READ) || (st[b] == ST_WRITE);
         assign wbeat_v[b] = beats && (st[b] == ST_WRITE);
         assign bank_state[2*b +: 2]       = st[b];
         assign open_row[ADDR_W*b +: ADDR_W] = row_v[b];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q      <= '0;
         mode_load_q <= 1'b0;
         illegal_q   <= 1'b0;
      end else begin
         if (legal && cmd == C_LMR) mode_q <= addr;
         mode_load_q <= legal && (cmd == C_LMR);
         illegal_q   <= !legal;
      end
   end

   assign mode_opcode = mode_q;
   assign mode_load   = mode_load_q;
   assign illegal_cmd = illegal_q;
   assign wr_win      = (legal && cmd == C_WR) || (|wbeat_v);

   sdr_dqm_timing #(.DQM_W(DQM_W), .RD_LAT(RD_MASK_LAT)) u_dqm (
      .clk     (clk),
      .rst_n   (rst_n),
      .dqm     (dqm),
      .wr_win  (wr_win),
      .wr_mask (wr_mask),
      .rd_mask (rd_mask)
   );

   AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      (!legal && !any_burst) |=> $stable(bank_state) && $stable(open_row)); // R3

   AST_MODE_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      mode_load |-> $past(all_idle)); // R6

   AST_SINGLE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(burst_v) <= 1); // R10

   AST_REFRESH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == C_REF && legal) |=> all_idle); // R4

endmodule

// File: tb/tb_sdr_cmd_tracker.sv
module tb_sdr_cmd_tracker;

   localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD  = 4'b0101,
                          K_WR  = 4'b0100, K_BST = 4'b0110, K_PRE = 4'b0010,
                          K_REF = 4'b0001, K_LMR = 4'b0000, K_INH = 4'b1000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [10:0] addr = '0;
   logic [3:0]  dqm = '0;
   logic [7:0]  bank_state;
   logic [43:0] open_row;
   logic        illegal_cmd, mode_load;
   logic [10:0] mode_opcode;
   logic [3:0]  wr_mask, rd_mask;

   int tests = 0, fails = 0;
   bit done = 0;
   logic [3:0] prev_dqm = '0;

   typedef struct {
      logic       ill;
      logic       ml;
      logic [7:0] st;
      logic [3:0] rdm;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;

   sdr_cmd_tracker dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm), .bank_state(bank_state),
      .open_row(open_row), .illegal_cmd(illegal_cmd), .mode_load(mode_load),
      .mode_opcode(mode_opcode), .wr_mask(wr_mask), .rd_mask(rd_mask)
   );

   task automatic chk(input bit ok, input string what, input logic [43:0] act, input logic [43:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // driver: applies one command, checks the zero-delay write mask, queues results
   task automatic step(input logic [3:0] c, input logic [1:0] b, input logic [10:0] a,
                       input logic [3:0] m, input logic e_ill, input logic e_ml,
                       input logic [7:0] e_st, input logic [3:0] e_wm, input string tag);
      exp_t it;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b; addr = a; dqm = m;
      #1;
      chk(wr_mask == e_wm, {tag, " R12 wr_mask"}, wr_mask, e_wm);
      it.ill = e_ill; it.ml = e_ml; it.st = e_st; it.rdm = prev_dqm; it.tag = tag;
      sb.push_back(it);
      prev_dqm = m;
   endtask

   // monitor: compares after the edge that registered each command
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(bank_state == e.st,  {e.tag, " bank_state"}, bank_state, e.st);
            chk(illegal_cmd == e.ill, {e.tag, " illegal_cmd"}, illegal_cmd, e.ill);
            chk(mode_load == e.ml,   {e.tag, " mode_load"}, mode_load, e.ml);
            chk(rd_mask == e.rdm,    {e.tag, " R11 rd_mask"}, rd_mask, e.rdm);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(bank_state == 8'h00, "R1 bank_state", bank_state, 0);
      chk(illegal_cmd == 0 && mode_load == 0, "R1 flags", {illegal_cmd, mode_load}, 0);
      chk(mode_opcode == 0, "R1 mode_opcode", mode_opcode, 0);
      chk(rd_mask == 0 && wr_mask == 0, "R1 masks", {rd_mask, wr_mask}, 0);

      step(K_RD,  0, 11'h000, 0, 1, 0, 8'h00, 0, "R3 read to idle bank");
      step(K_ACT, 0, 11'h123, 0, 0, 0, 8'h01, 0, "R2 activate bank0");
      step(K_ACT, 0, 11'h0AA, 0, 1, 0, 8'h01, 0, "R3 activate open bank");
      step(K_ACT, 2, 11'h055, 0, 0, 0, 8'h11, 0, "R2 activate bank2");
      chk(open_row[10:0] == 11'h123, "R2 R3 row bank0", open_row[10:0], 11'h123);
      step(K_LMR, 0, 11'h003, 0, 1, 0, 8'h11, 0, "R6 mode load with open rows");
      chk(open_row[32:22] == 11'h055, "R2 row bank2", open_row[32:22], 11'h055);
      step(K_PRE, 0, 11'h000, 0, 0, 0, 8'h10, 0, "R5 single precharge");
      step(K_PRE, 1, 11'h400, 0, 0, 0, 8'h00, 0, "R5 precharge all");
      step(K_LMR, 0, 11'h002, 0, 0, 1, 8'h00, 0, "R6 mode load length 4");
      step(K_NOP, 0, 11'h000, 0, 0, 0, 8'h00, 0, "R6 strobe one cycle");
      chk(mode_opcode == 11'h002, "R6 opcode", mode_opcode, 11'h002);

      step(K_ACT, 1, 11'h007, 0,    0, 0, 8'h04, 0, "R2 activate bank1");
      step(K_RD,  1, 11'h000, 0,    0, 0, 8'h08, 0, "R7 read length 4");
      step(K_NOP, 0, 11'h000, 4'h3, 0, 0, 8'h08, 0, "R7 read beat");
      step(K_NOP, 0, 11'h000, 4'hC, 0, 0, 8'h08, 0, "R7 read beat");
      step(K_NOP, 0, 11'h000, 4'hF, 0, 0, 8'h08, 0, "R7 read beat");
      step(K_NOP, 0, 11'h000, 0,    0, 0, 8'h04, 0, "R7 read burst ended");

      step(K_WR,  1, 11'h400, 4'hA, 0, 0, 8'h0C, 4'hA, "R8 write with auto-precharge");
      step(K_NOP, 0, 11'h000, 4'h5, 0, 0, 8'h0C, 4'h5, "R12 write beat mask");
      step(K_NOP, 0, 11'h000, 4'h0, 0, 0, 8'h0C, 4'h0, "R12 write beat");
      step(K_NOP, 0, 11'h000, 4'h9, 0, 0, 8'h0C, 4'h9, "R12 last write beat");
      step(K_NOP, 0, 11'h000, 4'h6, 0, 0, 8'h00, 4'h0, "R8 auto-precharge to idle");

      step(K_ACT, 1, 11'h011, 0, 0, 0, 8'h04, 0, "R8 reopen bank1");
      step(K_RD,  1, 11'h000, 0, 0, 0, 8'h08, 0, "R8 read without auto-precharge");
      step(K_NOP, 0, 11'h000, 0, 0, 0, 8'h08, 0, "R7 read beat");
      step(K_BST, 3, 11'h000, 0, 0, 0, 8'h04, 0, "R9 burst stop");
      step(K_BST, 0, 11'h000, 0, 1, 0, 8'h04, 0, "R9 stop without burst");

      step(K_ACT, 3, 11'h009, 0, 0, 0, 8'h44, 0, "R2 activate bank3");
      step(K_RD,  1, 11'h000, 0, 0, 0, 8'h48, 0, "R10 read bank1");
      step(K_WR,  3, 11'h000, 0, 0, 0, 8'hC4, 0, "R10 write cuts read");
      step(K_PRE, 3, 11'h000, 0, 0, 0, 8'h04, 0, "R10 precharge truncates write");

      step(K_REF, 0, 11'h000, 0, 1, 0, 8'h04, 0, "R4 refresh with open row");
      step(K_PRE, 2, 11'h400, 0, 0, 0, 8'h00, 0, "R5 precharge all ignores ba");
      step(K_REF, 0, 11'h000, 0, 0, 0, 8'h00, 0, "R4 refresh when idle");
      step(K_INH, 1, 11'h7FF, 0, 0, 0, 8'h00, 0, "R3 inhibit ignored");

      step(K_LMR, 0, 11'h007, 0, 0, 1, 8'h00, 0, "R7 load open-ended burst");
      step(K_ACT, 0, 11'h001, 0, 0, 0, 8'h01, 0, "R2 activate bank0");
      step(K_RD,  0, 11'h400, 0, 0, 0, 8'h02, 0, "R7 open-ended read");
      for (int i = 0; i < 10; i++)
         step(K_NOP, 0, 11'h000, 0, 0, 0, 8'h02, 0, "R7 open-ended read continues");
      step(K_BST, 0, 11'h000, 0, 0, 0, 8'h01, 0, "R9 stop open-ended read");
      step(K_WR,  0, 11'h000, 0,    0, 0, 8'h03, 0,    "R7 open-ended write");
      step(K_NOP, 0, 11'h000, 4'hE, 0, 0, 8'h03, 4'hE, "R12 open-ended write mask");
      step(K_PRE, 0, 11'h000, 0,    0, 0, 8'h00, 0,    "R10 precharge ends write");
      step(K_WR,  2, 11'h000, 0,    1, 0, 8'h00, 0,    "R3 write to idle bank");
      step(K_NOP, 0, 11'h000, 0,    0, 0, 8'h00, 0,    "R3 flag clears");

      repeat (3) @(posedge clk);
      #6;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule